// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

A synchronous controller that sits between an internal request port and an external byte-wide asynchronous static RAM with a 19-bit address space. A request carries an address, a direction flag and write data. It is taken only while the controller is idle. The controller then sequences the memory's active-low select, write and output strobes, drives or releases an 8-bit data bus, and returns a one-cycle response. For reads, the response carries the byte it sampled from the bus.

Each phase of an access lasts a whole number of clock cycles. The counts are derived at elaboration time from the clock period and the memory's minimum nanosecond timings, each rounded up to whole cycles. A write keeps select and write strobe low together long enough to cover the pulse width, the address-to-end window, the data-to-end window and the full cycle time. A read keeps select and output strobe low until the slower of the address access time and the output-enable access time has passed, and samples on that edge. After every read, a turnaround gap lets the memory release the bus before the controller can drive it. Between requests the memory stays deselected so that it drops into its own standby mode. The data bus is split into an output value, an input value and an output-enable.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and after reset is released, sram_ce_n_o, sram_we_n_o and sram_oe_n_o are 1, sram_dq_oe_o is 0, req_ready_o is 1 and rsp_valid_o is 0.
- R2: A write request is accepted on clock edge k. From that edge, sram_ce_n_o and sram_we_n_o are 0 for exactly W cycles. During that time sram_addr_o holds the request address and sram_oe_n_o stays 1. Both strobes return to 1 on the same edge.
- R3: From edge k of an accepted write, sram_dq_oe_o is 1 and sram_dq_o equals the write byte. Both hold for one cycle after the strobes return high, then sram_dq_oe_o drops to 0.
- R4: A read request is accepted on edge k. From that edge, sram_ce_n_o and sram_oe_n_o are 0 for exactly R cycles, with sram_we_n_o at 1, sram_dq_oe_o at 0 and sram_addr_o at the request address.
- R5: sram_dq_i is sampled on the edge that ends the read window. In the cycle after that edge, rsp_valid_o is 1 for exactly one cycle and rsp_rdata_o carries the sampled byte.
- R6: req_ready_o is 1 only in the idle state. A request held valid through a busy period is accepted again only after the controller returns to idle, so each idle cycle accepts at most one request.
- R7: After a read ends, the controller stays busy for T turnaround cycles. sram_dq_oe_o stays 0 for at least T+1 cycles after sram_oe_n_o rises, and this holds even when a write is queued immediately.
- R8: Whenever the controller is idle (req_ready_o is 1), sram_ce_n_o is 1.
- R9: sram_we_n_o is never 0 while sram_oe_n_o is 0, and sram_dq_oe_o is 1 only while sram_oe_n_o is 1.
- R10: W is the largest of ceil(40/P), ceil(45/P), ceil(25/P) and ceil(55/P). R is the largest of ceil(55/P) and ceil(30/P). T is the larger of 1 and ceil(20/P). P is the clock period in ns. With the default P=20 this gives W=3, R=3 and T=1, and the memory's pulse, address, data and contention limits are all met.
- R11: A write completes with rsp_valid_o at 1 for exactly one cycle: the first cycle in which sram_we_n_o is back at 1. rsp_rdata_o keeps the last read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle and accepting |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 19 | Word address |
| req_wdata_i | input | 8 | Write byte |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 8 | Byte sampled by the last read |
| sram_addr_o | output | 19 | Memory address |
| sram_ce_n_o | output | 1 | Memory select, active low |
| sram_we_n_o | output | 1 | Memory write strobe, active low |
| sram_oe_n_o | output | 1 | Memory output strobe, active low |
| sram_dq_o | output | 8 | Data driven toward the memory |
| sram_dq_i | input | 8 | Data returned from the memory |
| sram_dq_oe_o | output | 1 | Enable for the controller's data drivers |

## Verification
Single writes and reads are tried at the lowest and highest addresses and with the 00, FF, 55 and AA data patterns, which separate a stuck or swapped data bit from a correct path. A sweep of random writes followed by read-back separates address decoding faults from strobe timing faults. A behavioural memory model returns inverted data until its access time has elapsed, so a read window that is too short shows up as a data error rather than passing silently. A read followed at once by a write, and a request held valid across a busy period, separate a correct turnaround and one-acceptance-per-idle rule from a controller that re-accepts early or drives the bus while the memory still does.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/100ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WR_PULSE  = 3'd1,
    ST_WR_HOLD   = 3'd2,
    ST_RD_ACCESS = 3'd3,
    ST_RD_TURN   = 3'd4
  } ctrl_state_e;

  // ceil(ns / period); zero stays zero
  function automatic int ns_to_cyc(input int ns, input int period);
    if (ns <= 0) return 0;
    return (ns + period - 1) / period;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
`timescale 1ns/100ps
module sram_phase_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/100ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int WR_CYC   = 3,
  parameter int RD_CYC   = 3,
  parameter int TURN_CYC = 1,
  parameter int CNT_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  output logic             req_ready_o,
  input  logic             cnt_done_i,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_val_o,
  output logic             accept_o,
  output logic             sample_o,
  output logic             ce_n_o,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic             drv_o,
  output logic             rsp_valid_o
);

  localparam logic [CNT_W-1:0] WR_LD   = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

  ctrl_state_e state_q, state_d;
  logic ce_n_q, ce_n_d;
  logic we_n_q, we_n_d;
  logic oe_n_q, oe_n_d;
  logic drv_q, drv_d;
  logic rsp_q, rsp_d;

  always_comb begin
    state_d    = state_q;
    ce_n_d     = ce_n_q;
    we_n_d     = we_n_q;
    oe_n_d     = oe_n_q;
    drv_d      = drv_q;
    rsp_d      = 1'b0;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    accept_o   = 1'b0;
    sample_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          accept_o   = 1'b1;
          cnt_load_o = 1'b1;
          ce_n_d     = 1'b0;
          if (req_we_i) begin
            state_d   = ST_WR_PULSE;
            we_n_d    = 1'b0;
            drv_d     = 1'b1;
            cnt_val_o = WR_LD;
          end else begin
            state_d   = ST_RD_ACCESS;
            oe_n_d    = 1'b0;
            cnt_val_o = RD_LD;
          end
        end
      end
      ST_WR_PULSE: begin
        if (cnt_done_i) begin
          // end write on both strobes at once; data held one more cycle
          state_d = ST_WR_HOLD;
          ce_n_d  = 1'b1;
          we_n_d  = 1'b1;
          rsp_d   = 1'b1;
        end
      end
      ST_WR_HOLD: begin
        state_d = ST_IDLE;
        drv_d   = 1'b0;
      end
      ST_RD_ACCESS: begin
        if (cnt_done_i) begin
          sample_o   = 1'b1;
          rsp_d      = 1'b1;
          ce_n_d     = 1'b1;
          oe_n_d     = 1'b1;
          state_d    = ST_RD_TURN;
          cnt_load_o = 1'b1;
          cnt_val_o  = TURN_LD;
        end
      end
      ST_RD_TURN: begin
        if (cnt_done_i) state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        ce_n_d  = 1'b1;
        we_n_d  = 1'b1;
        oe_n_d  = 1'b1;
        drv_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ce_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      drv_q   <= 1'b0;
      rsp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n_q  <= ce_n_d;
      we_n_q  <= we_n_d;
      oe_n_q  <= oe_n_d;
      drv_q   <= drv_d;
      rsp_q   <= rsp_d;
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign ce_n_o      = ce_n_q;
  assign we_n_o      = we_n_q;
  assign oe_n_o      = oe_n_q;
  assign drv_o       = drv_q;
  assign rsp_valid_o = rsp_q;

endmodule

// File: rtl/sram_dq_path.sv
`timescale 1ns/100ps
module sram_dq_path #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sample_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (sample_i) begin
      rdata_q <= dq_i;
    end
  end

  assign addr_o  = addr_q;
  assign dq_o    = wdata_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/100ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_WP_NS       = 40,
  parameter int T_AW_NS       = 45,
  parameter int T_DW_NS       = 25,
  parameter int T_WC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_OE_NS       = 30,
  parameter int T_RC_NS       = 55,
  parameter int T_HZ_NS       = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_n_o,
  output logic              sram_we_n_o,
  output logic              sram_oe_n_o,
  output logic [DATA_W-1:0] sram_dq_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_dq_oe_o
);

  localparam int WR_CYC = max_int(max_int(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                          ns_to_cyc(T_AW_NS, CLK_PERIOD_NS)),
                                  max_int(max_int(ns_to_cyc(T_DW_NS, CLK_PERIOD_NS),
                                                  ns_to_cyc(T_WC_NS, CLK_PERIOD_NS)), 1));
  localparam int RD_CYC = max_int(max_int(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                          ns_to_cyc(T_OE_NS, CLK_PERIOD_NS)),
                                  max_int(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS), 1));
  localparam int TURN_CYC = max_int(ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS), 1);
  localparam int CNT_MAX  = max_int(max_int(WR_CYC, RD_CYC), TURN_CYC);
  localparam int CNT_W    = max_int($clog2(CNT_MAX), 1);

  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_done;
  logic             accept;
  logic             sample;

  sram_phase_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .done_o     (cnt_done)
  );

  sram_ctrl_fsm #(
    .WR_CYC   (WR_CYC),
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .req_ready_o (req_ready_o),
    .cnt_done_i  (cnt_done),
    .cnt_load_o  (cnt_load),
    .cnt_val_o   (cnt_val),
    .accept_o    (accept),
    .sample_o    (sample),
    .ce_n_o      (sram_ce_n_o),
    .we_n_o      (sram_we_n_o),
    .oe_n_o      (sram_oe_n_o),
    .drv_o       (sram_dq_oe_o),
    .rsp_valid_o (rsp_valid_o)
  );

  sram_dq_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .addr_i   (req_addr_i),
    .wdata_i  (req_wdata_i),
    .sample_i (sample),
    .dq_i     (sram_dq_i),
    .addr_o   (sram_addr_o),
    .dq_o     (sram_dq_o),
    .rdata_o  (rsp_rdata_o)
  );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/100ps
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_ce_n_o,
  input logic              sram_we_n_o,
  input logic              sram_oe_n_o,
  input logic              sram_dq_oe_o
);

  p_strobe_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_we_n_o && !sram_oe_n_o));

  p_drv_dir_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_n_o);

  p_idle_deselect_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> sram_ce_n_o);

  p_rsp_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_wr_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_n_o && $past(!sram_we_n_o)) |-> $stable(sram_addr_o));

  p_we_needs_ce_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_n_o |-> !sram_ce_n_o);

  p_wr_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_n_o |-> sram_dq_oe_o);

  p_turnaround_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_oe_n_o) |=> !sram_dq_oe_o);

  p_accept_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W (ADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .sram_addr_o  (sram_addr_o),
  .sram_ce_n_o  (sram_ce_n_o),
  .sram_we_n_o  (sram_we_n_o),
  .sram_oe_n_o  (sram_oe_n_o),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/100ps
module sram_async_ctrl_tb_top;

  localparam int W_EXP    = 3;
  localparam int R_EXP    = 3;
  localparam int WDOG_CYC = 20000;
  localparam int N_RAND   = 20;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_we;
  logic [18:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] sram_addr;
  logic        ce_n, we_n, oe_n;
  logic [7:0]  dq_o;
  logic [7:0]  dq_i;
  logic        dq_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] last_rd = 8'h00;

  sram_async_ctrl dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_ready_o  (req_ready),
    .req_we_i     (req_we),
    .req_addr_i   (req_addr),
    .req_wdata_i  (req_wdata),
    .rsp_valid_o  (rsp_valid),
    .rsp_rdata_o  (rsp_rdata),
    .sram_addr_o  (sram_addr),
    .sram_ce_n_o  (ce_n),
    .sram_we_n_o  (we_n),
    .sram_oe_n_o  (oe_n),
    .sram_dq_o    (dq_o),
    .sram_dq_i    (dq_i),
    .sram_dq_oe_o (dq_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // ---------------- behavioural memory model ----------------
  logic [7:0] mdl_mem [int];
  logic       mdl_on  = 1'b0;
  logic       mdl_drv = 1'b0;
  logic [7:0] mdl_out = 8'h00;

  assign dq_i = mdl_drv ? mdl_out : 8'h00;

  function automatic logic [7:0] mem_rd(input logic [18:0] a);
    if (mdl_mem.exists(int'(a))) return mdl_mem[int'(a)];
    return 8'h00;
  endfunction

  initial begin
    realtime now;
    realtime t_addr = 0.0, t_ce = 0.0, t_oe = 0.0, t_data = 0.0, t_ws = 0.0;
    realtime t_rel = -100.0;
    logic [18:0] addr_q = '0, wr_addr = '0;
    logic ce_q = 1'b1, oe_q = 1'b1, dqoe_q = 1'b0;
    logic [7:0] dq_q = 8'h00;
    logic wr, rd, wr_q = 1'b0, rd_q = 1'b0, valid;
    #0.5;
    forever begin
      if (mdl_on) begin
        now = $realtime;
        if (sram_addr != addr_q) begin t_addr = now; addr_q = sram_addr; end
        if (ce_n != ce_q) begin if (!ce_n) t_ce = now; ce_q = ce_n; end
        if (oe_n != oe_q) begin if (!oe_n) t_oe = now; oe_q = oe_n; end
        if (dq_o != dq_q || dq_oe != dqoe_q) begin t_data = now; dq_q = dq_o; dqoe_q = dq_oe; end
        wr = !ce_n && !we_n;
        if (wr && !wr_q) begin t_ws = now; wr_addr = sram_addr; end
        if (wr && sram_addr != wr_addr)
          chk(1'b0, "R10 model address moved during write", longint'(sram_addr), longint'(wr_addr));
        if (!wr && wr_q) begin
          chk(now - t_ws >= 40.0, "R10 model write pulse ns", longint'(now - t_ws), 40);
          chk(now - t_addr >= 45.0, "R10 model address to end ns", longint'(now - t_addr), 45);
          chk(now - t_data >= 25.0 && dq_oe, "R10 model data to end ns", longint'(now - t_data), 25);
          mdl_mem[int'(wr_addr)] = dq_o;
        end
        rd = !ce_n && !oe_n && we_n;
        if (!rd && rd_q) t_rel = now;
        valid = rd && (now - t_addr >= 55.0) && (now - t_ce >= 55.0) && (now - t_oe >= 30.0);
        mdl_drv = rd || (now - t_rel < 19.5);
        mdl_out = valid ? mem_rd(sram_addr) : ~mem_rd(sram_addr);
        if (mdl_drv && dq_oe)
          chk(1'b0, "R7 model bus contention", 1, 0);
        wr_q = wr;
        rd_q = rd;
      end
      #1;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    #(WDOG_CYC * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", WDOG_CYC, 0);
    finish_run();
  end

  // ---------------- scenarios ----------------
  task automatic t_reset();
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    #3;
    chk(ce_n && we_n && oe_n, "R1 strobes high in reset", {ce_n, we_n, oe_n}, 7);
    chk(!dq_oe, "R1 driver off in reset", dq_oe, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mdl_on = 1'b1;
    @(negedge clk);
    chk(ce_n && we_n && oe_n, "R1 strobes high after reset", {ce_n, we_n, oe_n}, 7);
    chk(req_ready && !rsp_valid && !dq_oe, "R1 idle after reset", {req_ready, rsp_valid, dq_oe}, 4);
  endtask

  // starts and ends at a negedge with the controller idle
  task automatic t_write(input logic [18:0] a, input logic [7:0] d);
    int n = 0;
    chk(req_ready, "R6 ready in idle before write", req_ready, 1);
    chk(ce_n, "R8 deselected while idle", ce_n, 1);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(dq_oe && dq_o == d, "R3 write data driven", dq_o, d);
    chk(oe_n, "R2 oe_n high in write", oe_n, 1);
    while (!we_n && n < 10) begin
      n++;
      chk(!ce_n && sram_addr == a, "R2 select and address in write", sram_addr, a);
      chk(!req_ready, "R6 not ready while busy", req_ready, 0);
      @(negedge clk);
    end
    chk(n == W_EXP, "R10 write pulse cycles", n, W_EXP);
    chk(ce_n, "R2 strobes end together", ce_n, 1);
    chk(rsp_valid, "R11 write ack pulse", rsp_valid, 1);
    chk(rsp_rdata == last_rd, "R11 rdata unchanged on write", rsp_rdata, last_rd);
    chk(dq_oe && dq_o == d, "R3 data held after write end", dq_o, d);
    @(negedge clk);
    chk(!dq_oe, "R3 driver off after hold", dq_oe, 0);
    chk(!rsp_valid, "R11 ack lasts one cycle", rsp_valid, 0);
    chk(req_ready && ce_n, "R8 idle and deselected after write", {req_ready, ce_n}, 3);
  endtask

  task automatic t_read(input logic [18:0] a, input logic [7:0] e);
    int n = 0;
    chk(req_ready, "R6 ready in idle before read", req_ready, 1);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    while (!oe_n && n < 10) begin
      n++;
      chk(!ce_n && we_n && !dq_oe, "R4 read strobes", {ce_n, we_n, dq_oe}, 2);
      chk(sram_addr == a, "R4 read address", sram_addr, a);
      chk(!rsp_valid, "R5 no response before sample", rsp_valid, 0);
      @(negedge clk);
    end
    chk(n == R_EXP, "R10 read window cycles", n, R_EXP);
    chk(rsp_valid, "R5 read response pulse", rsp_valid, 1);
    chk(rsp_rdata == e, "R5 read data", rsp_rdata, e);
    chk(ce_n, "R4 select released with output strobe", ce_n, 1);
    chk(!req_ready && !dq_oe, "R7 turnaround busy", {req_ready, dq_oe}, 0);
    last_rd = rsp_rdata;
    @(negedge clk);
    chk(!rsp_valid, "R5 response one cycle", rsp_valid, 0);
    chk(req_ready && ce_n, "R8 idle after turnaround", {req_ready, ce_n}, 3);
  endtask

  task automatic t_turn_rd_wr();
    t_write(19'h00123, 8'h3C);
    t_read(19'h00123, 8'h3C);
    // two cycles after oe_n rose; write issued now may drive only next cycle
    chk(!dq_oe, "R7 no drive before write start", dq_oe, 0);
    t_write(19'h00124, 8'hC3);
    t_read(19'h00124, 8'hC3);
  endtask

  task automatic t_held_req();
    int rdy = 0, rsp = 0;
    req_valid = 1'b1; req_we = 1'b0; req_addr = 19'h00123;
    for (int i = 0; i < 10; i++) begin
      if (req_ready) rdy++;
      if (rsp_valid) begin
        rsp++;
        chk(rsp_rdata == 8'h3C, "R6 held read data", rsp_rdata, 8'h3C);
      end
      if (i < 9) @(negedge clk);
    end
    req_valid = 1'b0;
    chk(rdy == 2, "R6 idle cycles in held window", rdy, 2);
    chk(rsp == 2, "R6 one accept per idle", rsp, 2);
    @(negedge clk);
    chk(req_ready, "R6 idle after held request dropped", req_ready, 1);
    last_rd = rsp_rdata;
  endtask

  task automatic t_patterns();
    t_write(19'h00000, 8'h00);
    t_write(19'h7FFFF, 8'hFF);
    t_write(19'h2AAAA, 8'h55);
    t_write(19'h55555, 8'hAA);
    t_read(19'h00000, 8'h00);
    t_read(19'h7FFFF, 8'hFF);
    t_read(19'h2AAAA, 8'h55);
    t_read(19'h55555, 8'hAA);
  endtask

  task automatic t_random();
    logic [18:0] ra [N_RAND];
    logic [7:0]  rd [N_RAND];
    for (int i = 0; i < N_RAND; i++) begin
      ra[i] = {14'($urandom), 5'(i)};
      rd[i] = 8'($urandom);
      t_write(ra[i], rd[i]);
    end
    for (int i = 0; i < N_RAND; i++) t_read(ra[i], rd[i]);
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_turn_rd_wr();
    t_held_req();
    t_random();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule